// File: doc/BRIEF.md
# Second-Operand Shifter with Carry

This block forms the second operand of a 32-bit ALU in a single combinational pass. In immediate form it takes an 8-bit constant and rotates it right by twice a 4-bit rotate field. In register form it passes a 32-bit register value through one of five shift operations, or passes it through unchanged: logical left, logical right, arithmetic right, rotate right, and a one-bit rotate through the carry flag. The shift amount comes either from a 5-bit field of the instruction or from the low byte of a second register.

Alongside the operand the block produces the shifter carry-out. The current carry flag is an input. Each operand form has its own rule for this carry. The ALU and the flag register sit outside the block, and the ALU decides whether the shifter carry is written to the flags.

Top module: `op2_barrel_shifter`

## Requirements
- R1: With `use_imm`=1, `op_out` equals the 8-bit `imm_val`, zero-extended to 32 bits and rotated right by 2×`imm_rot` positions (0 to 30).
- R2: With `use_imm`=1, `carry_out` equals bit 31 of `op_out` when `imm_rot` is non-zero, and `carry_in` when `imm_rot` is zero.
- R3: With `use_imm`=0, `shift_kind` selects the operation: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right, 4 rotate right through carry. Codes 5 to 7 pass `rm_val` unchanged with `carry_out`=`carry_in`. `amt_from_reg`=1 takes the amount from `amt_reg` (0 to 255); `amt_from_reg`=0 takes it from `amt_imm` (0 to 31).
- R4: For codes 0 to 3, an amount of zero from either source passes `rm_val` unchanged with `carry_out`=`carry_in`.
- R5: Logical left by n (1 to 31) fills with zeros from the right. `carry_out` is input bit 32−n.
- R6: Logical right by n (1 to 31) fills with zeros from the left. Arithmetic right by n (1 to 31) fills with copies of input bit 31. In both cases `carry_out` is input bit n−1.
- R7: Rotate right by n wraps low bits into the top and uses n modulo 32. If n mod 32 is non-zero, `carry_out` is bit 31 of the result. If n is a non-zero multiple of 32, the value passes unchanged and `carry_out` is input bit 31.
- R8: Rotate through carry gives {`carry_in`, `rm_val`[31:1]} with `carry_out`=`rm_val`[0]. It ignores both amount inputs.
- R9: With a register amount, logical left or logical right by exactly 32 gives zero, with `carry_out` equal to input bit 0 (left) or input bit 31 (right). Either shift by more than 32 gives zero with `carry_out`=0.
- R10: With a register amount of 32 or more, arithmetic right fills all 32 bits with input bit 31, and `carry_out` equals input bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| use_imm | input | 1 | 1 selects the rotated-constant form, 0 the shifted-register form |
| imm_val | input | 8 | Constant for the immediate form |
| imm_rot | input | 4 | Rotate field; the constant is rotated right by twice this value |
| rm_val | input | 32 | Register value to shift |
| shift_kind | input | 3 | Shift operation code (see R3) |
| amt_from_reg | input | 1 | 1 takes the amount from `amt_reg`, 0 from `amt_imm` |
| amt_imm | input | 5 | Instruction-field shift amount |
| amt_reg | input | 8 | Low byte of the amount register |
| carry_in | input | 1 | Current carry flag |
| op_out | output | 32 | Second operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
The immediate form is swept over every constant, every rotate field and both carry values. This covers zero rotation against non-zero rotation, and rotations that wrap the constant across bit 31. The register form is swept over all eight operation codes with every 5-bit field amount and every 8-bit register amount, applied to four data words and both carry values. The data words have different sign bits and end bits, so a carry taken from the wrong position shows up. The register sweep reaches 0, 31, 32, 33 and 255, which separates the in-range, exactly-32 and beyond-32 rules from each other. While one amount source is selected, the other holds a different value, so selecting the wrong source changes the result.

// File: rtl/op2_shift_pkg.sv
package op2_shift_pkg;

   // Shift operation codes driven on shift_kind; other codes pass through.
   typedef enum logic [2:0] {
      SK_LSL = 3'd0,
      SK_LSR = 3'd1,
      SK_ASR = 3'd2,
      SK_ROR = 3'd3,
      SK_RRX = 3'd4
   } shift_kind_e;

   // Amount classes used by the register-form datapath.
   typedef struct packed {
      logic is_zero;
      logic eq_width;
      logic gt_width;
   } amt_class_t;

endpackage

// File: rtl/op2_rotr.sv
// Logarithmic right rotator: one stage per amount bit.
module op2_rotr #(
   parameter int W  = 32,
   parameter int SW = 5
) (
   input  logic [W-1:0]  din,
   input  logic [SW-1:0] amt,
   output logic [W-1:0]  dout
);

   logic [W-1:0] stage [0:SW];

   assign stage[0] = din;

   for (genvar s = 0; s < SW; s++) begin : g_stage
      localparam int D = (1 << s) % W;
      if (D == 0) begin : g_none
         assign stage[s+1] = stage[s];
      end else begin : g_rot
         assign stage[s+1] = amt[s] ? {stage[s][D-1:0], stage[s][W-1:D]} : stage[s];
      end
   end

   assign dout = stage[SW];

endmodule

// File: rtl/op2_bitrev.sv
// Bit-order reversal, used to run left shifts through the right-shift path.
module op2_bitrev #(
   parameter int W = 32
) (
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   for (genvar i = 0; i < W; i++) begin : g_bit
      assign dout[i] = din[W-1-i];
   end

endmodule

// File: rtl/op2_imm_rot.sv
// Rotated-constant operand: zero-extended constant rotated right by 2*rot.
module op2_imm_rot #(
   parameter int W      = 32,
   parameter int IMM_W  = 8,
   parameter int ROT_W  = 4,
   parameter int SAMT_W = 5
) (
   input  logic [IMM_W-1:0] imm_val,
   input  logic [ROT_W-1:0] imm_rot,
   input  logic             carry_in,
   output logic [W-1:0]     res,
   output logic             carry
);

   localparam int PAD_W = W - IMM_W;

   logic [W-1:0]      imm_ext;
   logic [SAMT_W-1:0] rot_amt;

   assign imm_ext = {{PAD_W{1'b0}}, imm_val};
   assign rot_amt = SAMT_W'({imm_rot, 1'b0});

   op2_rotr #(.W(W), .SW(SAMT_W)) u_rot (
      .din  (imm_ext),
      .amt  (rot_amt),
      .dout (res)
   );

   assign carry = (imm_rot != '0) ? res[W-1] : carry_in;

endmodule

// File: rtl/op2_amount.sv
// Amount selection and classification against the data width.
module op2_amount
   import op2_shift_pkg::*;
#(
   parameter int W      = 32,
   parameter int SAMT_W = 5,
   parameter int RAMT_W = 8
) (
   input  logic              amt_from_reg,
   input  logic [SAMT_W-1:0] amt_imm,
   input  logic [RAMT_W-1:0] amt_reg,
   output amt_class_t        cls,
   output logic [SAMT_W-1:0] amt_low
);

   localparam logic [RAMT_W-1:0] W_R = RAMT_W'(W);

   always_comb begin
      if (amt_from_reg) begin
         cls.is_zero  = (amt_reg == '0);
         cls.eq_width = (amt_reg == W_R);
         cls.gt_width = (amt_reg > W_R);
         amt_low      = amt_reg[SAMT_W-1:0];
      end else begin
         cls.is_zero  = (amt_imm == '0);
         cls.eq_width = 1'b0;
         cls.gt_width = 1'b0;
         amt_low      = amt_imm;
      end
   end

endmodule

// File: rtl/op2_shift_core.sv
// Register-form shifter: all shifts share one right rotator plus masks.
module op2_shift_core
   import op2_shift_pkg::*;
#(
   parameter int W      = 32,
   parameter int SAMT_W = 5
) (
   input  logic [W-1:0]      x,
   input  logic [2:0]        kind,
   input  amt_class_t        cls,
   input  logic [SAMT_W-1:0] amt_low,
   input  logic              carry_in,
   output logic [W-1:0]      res,
   output logic              carry
);

   logic [W-1:0]      x_rev, src, rot, mask_r, log_r, ar_r, lsl_res;
   logic [SAMT_W-1:0] idx_l, idx_r;
   logic              sign;

   op2_bitrev #(.W(W)) u_rev_in (.din(x), .dout(x_rev));

   assign src = (kind == SK_LSL) ? x_rev : x;

   op2_rotr #(.W(W), .SW(SAMT_W)) u_rot (
      .din  (src),
      .amt  (amt_low),
      .dout (rot)
   );

   assign sign   = x[W-1];
   assign mask_r = {W{1'b1}} >> amt_low;
   assign log_r  = rot & mask_r;
   assign ar_r   = log_r | ({W{sign}} & ~mask_r);

   op2_bitrev #(.W(W)) u_rev_out (.din(log_r), .dout(lsl_res));

   // idx_l = W - n (modulo W), idx_r = n - 1
   assign idx_l = SAMT_W'(0) - amt_low;
   assign idx_r = amt_low - SAMT_W'(1);

   always_comb begin
      res   = x;
      carry = carry_in;
      if (kind == SK_RRX) begin
         res   = {carry_in, x[W-1:1]};
         carry = x[0];
      end else if (kind <= SK_ROR && !cls.is_zero) begin
         case (kind)
            SK_LSL: begin
               if (cls.gt_width) begin
                  res = '0; carry = 1'b0;
               end else if (cls.eq_width) begin
                  res = '0; carry = x[0];
               end else begin
                  res = lsl_res; carry = x[idx_l];
               end
            end
            SK_LSR: begin
               if (cls.gt_width) begin
                  res = '0; carry = 1'b0;
               end else if (cls.eq_width) begin
                  res = '0; carry = x[W-1];
               end else begin
                  res = log_r; carry = x[idx_r];
               end
            end
            SK_ASR: begin
               if (cls.gt_width || cls.eq_width) begin
                  res = {W{sign}}; carry = sign;
               end else begin
                  res = ar_r; carry = x[idx_r];
               end
            end
            default: begin
               if (amt_low == '0) begin
                  res = x; carry = x[W-1];
               end else begin
                  res = rot; carry = rot[W-1];
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/op2_barrel_shifter.sv
module op2_barrel_shifter
   import op2_shift_pkg::*;
#(
   parameter  int W      = 32,
   parameter  int IMM_W  = 8,
   parameter  int ROT_W  = 4,
   parameter  int RAMT_W = 8,
   localparam int SAMT_W = $clog2(W)
) (
   input  logic              use_imm,
   input  logic [IMM_W-1:0]  imm_val,
   input  logic [ROT_W-1:0]  imm_rot,
   input  logic [W-1:0]      rm_val,
   input  logic [2:0]        shift_kind,
   input  logic              amt_from_reg,
   input  logic [SAMT_W-1:0] amt_imm,
   input  logic [RAMT_W-1:0] amt_reg,
   input  logic              carry_in,
   output logic [W-1:0]      op_out,
   output logic              carry_out
);

   if ((1 << SAMT_W) != W) begin : g_bad_width
      $error("op2_barrel_shifter: W must be a power of two");
   end
   if (IMM_W > W) begin : g_bad_imm
      $error("op2_barrel_shifter: IMM_W wider than W");
   end
   if (2 * ((1 << ROT_W) - 1) >= W) begin : g_bad_rot
      $error("op2_barrel_shifter: rotate field reaches a full turn");
   end
   if (RAMT_W <= SAMT_W) begin : g_bad_ramt
      $error("op2_barrel_shifter: register amount must reach W");
   end

   logic [W-1:0]      imm_res, sh_res;
   logic              imm_c, sh_c;
   amt_class_t        cls;
   logic [SAMT_W-1:0] amt_low;

   op2_imm_rot #(.W(W), .IMM_W(IMM_W), .ROT_W(ROT_W), .SAMT_W(SAMT_W)) u_imm (
      .imm_val  (imm_val),
      .imm_rot  (imm_rot),
      .carry_in (carry_in),
      .res      (imm_res),
      .carry    (imm_c)
   );

   op2_amount #(.W(W), .SAMT_W(SAMT_W), .RAMT_W(RAMT_W)) u_amt (
      .amt_from_reg (amt_from_reg),
      .amt_imm      (amt_imm),
      .amt_reg      (amt_reg),
      .cls          (cls),
      .amt_low      (amt_low)
   );

   op2_shift_core #(.W(W), .SAMT_W(SAMT_W)) u_core (
      .x        (rm_val),
      .kind     (shift_kind),
      .cls      (cls),
      .amt_low  (amt_low),
      .carry_in (carry_in),
      .res      (sh_res),
      .carry    (sh_c)
   );

   assign op_out    = use_imm ? imm_res : sh_res;
   assign carry_out = use_imm ? imm_c   : sh_c;

endmodule

// File: rtl/op2_barrel_shifter_chk.sv
module op2_barrel_shifter_chk
   import op2_shift_pkg::*;
#(
   parameter  int W      = 32,
   parameter  int IMM_W  = 8,
   parameter  int ROT_W  = 4,
   parameter  int RAMT_W = 8,
   localparam int SAMT_W = $clog2(W)
) (
   input logic              use_imm,
   input logic [IMM_W-1:0]  imm_val,
   input logic [ROT_W-1:0]  imm_rot,
   input logic [W-1:0]      rm_val,
   input logic [2:0]        shift_kind,
   input logic              amt_from_reg,
   input logic [SAMT_W-1:0] amt_imm,
   input logic [RAMT_W-1:0] amt_reg,
   input logic              carry_in,
   input logic [W-1:0]      op_out,
   input logic              carry_out
);

   localparam int PAD_W = W - IMM_W;

   logic [RAMT_W-1:0] amt_eff;
   logic              known;

   assign amt_eff = amt_from_reg ? amt_reg : RAMT_W'(amt_imm);
   assign known   = !$isunknown({use_imm, imm_val, imm_rot, rm_val, shift_kind,
                                 amt_from_reg, amt_imm, amt_reg, carry_in,
                                 op_out, carry_out});

   always_comb begin
      if (known) begin
         // R1
         imm_unrotated_chk: assert (!(use_imm && imm_rot == '0) ||
                                    (op_out == {{PAD_W{1'b0}}, imm_val} && carry_out == carry_in))
            else $error("unrotated constant altered");
         // R2
         imm_carry_chk: assert (!(use_imm && imm_rot != '0) || carry_out == op_out[W-1])
            else $error("rotated constant carry wrong");
         // R3
         unknown_kind_chk: assert (use_imm || shift_kind <= 3'd4 ||
                                   (op_out == rm_val && carry_out == carry_in))
            else $error("unused code changed the operand");
         // R4
         zero_amount_chk: assert (use_imm || shift_kind > 3'd3 || amt_eff != '0 ||
                                  (op_out == rm_val && carry_out == carry_in))
            else $error("zero amount changed the operand");
         // R8
         rrx_chk: assert (use_imm || shift_kind != 3'd4 ||
                          (op_out == {carry_in, rm_val[W-1:1]} && carry_out == rm_val[0]))
            else $error("rotate through carry wrong");
         // R9
         far_shift_chk: assert (use_imm || !amt_from_reg || shift_kind > 3'd1 ||
                                amt_reg <= RAMT_W'(W) || (op_out == '0 && !carry_out))
            else $error("logical shift beyond width not cleared");
         // R10
         asr_fill_chk: assert (use_imm || !amt_from_reg || shift_kind != 3'd2 ||
                               amt_reg < RAMT_W'(W) ||
                               (op_out == {W{rm_val[W-1]}} && carry_out == rm_val[W-1]))
            else $error("arithmetic fill wrong");
      end
   end

endmodule

bind op2_barrel_shifter op2_barrel_shifter_chk #(
   .W(W), .IMM_W(IMM_W), .ROT_W(ROT_W), .RAMT_W(RAMT_W)
) u_chk (.*);

// File: tb/tb_op2_barrel_shifter.sv
module tb_op2_barrel_shifter;

   logic        clk = 1'b0;
   logic        use_imm = 1'b0;
   logic [7:0]  imm_val = '0;
   logic [3:0]  imm_rot = '0;
   logic [31:0] rm_val = '0;
   logic [2:0]  shift_kind = '0;
   logic        amt_from_reg = 1'b0;
   logic [4:0]  amt_imm = '0;
   logic [7:0]  amt_reg = '0;
   logic        carry_in = 1'b0;
   logic [31:0] op_out;
   logic        carry_out;

   int vectors = 0;
   int errors  = 0;

   always #4 clk = ~clk;

   op2_barrel_shifter dut (
      .use_imm(use_imm), .imm_val(imm_val), .imm_rot(imm_rot), .rm_val(rm_val),
      .shift_kind(shift_kind), .amt_from_reg(amt_from_reg), .amt_imm(amt_imm),
      .amt_reg(amt_reg), .carry_in(carry_in), .op_out(op_out), .carry_out(carry_out)
   );

   // Arithmetic reference derived from the requirements.
   task automatic model(output logic [31:0] r, output logic c, output string tag);
      logic [63:0] t;
      int n, m;
      if (use_imm) begin
         t   = {24'b0, imm_val, 24'b0, imm_val} >> (2 * int'(imm_rot));
         r   = t[31:0];
         c   = (imm_rot != 0) ? r[31] : carry_in;
         tag = "R1,R2";
         return;
      end
      n   = amt_from_reg ? int'(amt_reg) : int'(amt_imm);
      tag = "";
      if (shift_kind == 3'd4) begin
         r = {carry_in, rm_val[31:1]}; c = rm_val[0]; tag = "R8";
      end else if (shift_kind > 3'd4) begin
         r = rm_val; c = carry_in; tag = "R3";
      end else if (n == 0) begin
         r = rm_val; c = carry_in; tag = "R4";
      end else if (shift_kind == 3'd0) begin
         if (n <= 32) begin
            t = {32'b0, rm_val} << n; r = t[31:0]; c = t[32];
            tag = (n == 32) ? "R9" : "R5";
         end else begin
            r = '0; c = 1'b0; tag = "R9";
         end
      end else if (shift_kind == 3'd1) begin
         if (n <= 32) begin
            t = {rm_val, 32'b0} >> n; r = t[63:32]; c = t[31];
            tag = (n == 32) ? "R9" : "R6";
         end else begin
            r = '0; c = 1'b0; tag = "R9";
         end
      end else if (shift_kind == 3'd2) begin
         if (n >= 32) begin
            r = {32{rm_val[31]}}; c = rm_val[31]; tag = "R10";
         end else begin
            t = 64'($signed({rm_val, 32'b0}) >>> n); r = t[63:32]; c = t[31]; tag = "R6";
         end
      end else begin
         m = n % 32;
         if (m == 0) begin
            r = rm_val; c = rm_val[31];
         end else begin
            t = {rm_val, rm_val} >> m; r = t[31:0]; c = r[31];
         end
         tag = "R7";
      end
      if (amt_from_reg) tag = {tag, " R3"};
   endtask

   task automatic check_now();
      logic [31:0] er;
      logic        ec;
      string       tag;
      @(negedge clk);
      model(er, ec, tag);
      vectors++;
      if (op_out !== er || carry_out !== ec) begin
         errors++;
         $display("FAIL %s: kind=%0d imm=%0b out=%h c=%b expected out=%h c=%b",
                  tag, shift_kind, use_imm, op_out, carry_out, er, ec);
      end
   endtask

   initial begin
      logic [31:0] pats [4];
      pats[0] = 32'hB6D5_9C2F;
      pats[1] = 32'h4A93_0E76;
      pats[2] = 32'h8000_0001;
      pats[3] = 32'h7FFF_0000;

      // R1 R2: every constant, rotate field and carry
      for (int v = 0; v < 256; v++)
         for (int rt = 0; rt < 16; rt++)
            for (int ci = 0; ci < 2; ci++) begin
               @(posedge clk);
               use_imm = 1'b1; imm_val = 8'(v); imm_rot = 4'(rt); carry_in = ci[0];
               rm_val = 32'hDEAD_BEEF; shift_kind = 3'(rt); amt_reg = 8'(v);
               check_now();
            end

      // R3..R10: every code, every amount from both sources
      for (int k = 0; k < 8; k++)
         for (int p = 0; p < 4; p++)
            for (int ci = 0; ci < 2; ci++) begin
               for (int a = 0; a < 256; a++) begin
                  @(posedge clk);
                  use_imm = 1'b0; shift_kind = 3'(k); rm_val = pats[p]; carry_in = ci[0];
                  amt_from_reg = 1'b1; amt_reg = 8'(a); amt_imm = ~5'(a) ^ 5'd3;
                  imm_val = 8'(a); imm_rot = 4'(k);
                  check_now();
               end
               for (int a = 0; a < 32; a++) begin
                  @(posedge clk);
                  use_imm = 1'b0; shift_kind = 3'(k); rm_val = pats[p]; carry_in = ci[0];
                  amt_from_reg = 1'b0; amt_imm = 5'(a); amt_reg = 8'(200 - a);
                  check_now();
               end
            end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL all requirements: watchdog expired, actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule